// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block turns one set of transfer parameters into the stream of source and destination byte addresses for a block-structured DMA move. A block is a row of frames, and each frame is a row of equally sized elements. A start pulse captures two base addresses, the element size, the element count, the frame count, and a per-side element stride and frame gap. The sequencer then offers one address pair per element on a valid/ready handshake. Each pair comes with the element size in bytes.

Inside a frame, each side moves by its own element stride, which counts from element start to element start. A stride of zero means the elements are packed. When a frame ends, the next frame begins one element size plus that side's frame gap past the last element. A one-dimensional mode moves only the first frame. A basic size mode accepts only 1, 2 or 4 bytes; an extended mode accepts any nonzero size. A bad parameter set raises an error pulse and no transfer starts. The data movement itself is left to the engine that consumes the addresses.

Top module: `dma2d_addr_seq`

## Requirements
- R1: After reset `busy`, `out_valid`, `done` and `err` are all low.
- R2: A start pulse seen while idle with legal parameters sets `busy` and `out_valid` from the next cycle. The first pair offered is the two base addresses, and `out_size` equals the captured element size.
- R3: Within a frame, after each accepted element each side's address advances by that side's element stride when the stride is nonzero.
- R4: When a side's element stride is zero, that side's address advances by exactly the element size inside a frame.
- R5: After the last element of a frame is accepted, each side's next address is that element's address plus the element size plus that side's frame gap.
- R6: With `cfg_two_d` low, only one frame of `cfg_elem_cnt` elements is issued, and the frame count is neither used nor checked.
- R7: A start while idle raises `err` for exactly one cycle and leaves the block idle when any of these holds: the element count is zero, the frame count is zero in 2-D mode, or the element size is not 1, 2 or 4 with `cfg_ext_size` low. With `cfg_ext_size` high any size from 1 to 65535 is legal and size 0 is an error.
- R8: A start pulse while busy is ignored, and changes to the parameter inputs during a transfer have no effect on the sequence.
- R9: While `out_valid` is high and `out_ready` is low, `out_src_addr`, `out_dst_addr`, `out_size` and `out_valid` hold their values.
- R10: `done` pulses high for one cycle in the cycle after the final element is accepted, with `busy` and `out_valid` low from that cycle. Exactly element count × frame count pairs are issued.
- R11: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the current parameters |
| cfg_ext_size | input | 1 | 1: any nonzero element size; 0: only 1, 2 or 4 |
| cfg_two_d | input | 1 | 1: all frames; 0: first frame only |
| cfg_elem_size | input | SIZE_W (16) | Element size in bytes |
| cfg_elem_cnt | input | CNT_W (16) | Elements per frame |
| cfg_frame_cnt | input | CNT_W (16) | Frames per block |
| cfg_src_base | input | ADDR_W (32) | Source start address |
| cfg_dst_base | input | ADDR_W (32) | Destination start address |
| cfg_src_elem_idx | input | IDX_W (16) | Source element stride, 0 = packed |
| cfg_dst_elem_idx | input | IDX_W (16) | Destination element stride, 0 = packed |
| cfg_src_frame_gap | input | IDX_W (16) | Source gap between frames in bytes |
| cfg_dst_frame_gap | input | IDX_W (16) | Destination gap between frames in bytes |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse on a rejected start |
| out_valid | output | 1 | Address pair offered |
| out_ready | input | 1 | Consumer accepts the pair |
| out_src_addr | output | ADDR_W (32) | Source address of the current element |
| out_dst_addr | output | ADDR_W (32) | Destination address of the current element |
| out_size | output | SIZE_W (16) | Element size in bytes |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
The assertions check several things on every cycle: the pair is held during a stall, `done` lasts one cycle and leaves the block idle, an error never coincides with activity, a start while busy never ends a transfer early, and the position counters stay inside their captured limits. The address values cannot be judged cycle by cycle. The stride, packing and frame-gap arithmetic, the 1-D truncation, wrap-around and the exact element total can only be shown by the bench scenarios, which compare every accepted pair against a model under random back-pressure.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_SRC  = 0;
  localparam int unsigned SIDE_DST  = 1;

  // Element size legality: extended mode takes any nonzero size,
  // basic mode only single, half and full words.
  function automatic logic size_legal(input logic ext, input logic [31:0] sz);
    if (ext) return (sz != 32'd0);
    return (sz == 32'd1) || (sz == 32'd2) || (sz == 32'd4);
  endfunction

endpackage

// File: rtl/dma2d_pos_ctr.sv
module dma2d_pos_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] elem_cnt,
  input  logic [CNT_W-1:0] frame_cnt,
  output logic             elem_end,
  output logic             xfer_end
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] elem_idx_q,   elem_idx_d;
  logic [CNT_W-1:0] frame_idx_q,  frame_idx_d;
  logic [CNT_W-1:0] elem_last_q,  elem_last_d;
  logic [CNT_W-1:0] frame_last_q, frame_last_d;
  logic             upd_en;

  assign elem_end = (elem_idx_q == elem_last_q);
  assign xfer_end = elem_end && (frame_idx_q == frame_last_q);
  assign upd_en   = load | adv;

  always_comb begin
    elem_idx_d   = elem_idx_q;
    frame_idx_d  = frame_idx_q;
    elem_last_d  = elem_last_q;
    frame_last_d = frame_last_q;
    if (load) begin
      elem_idx_d   = '0;
      frame_idx_d  = '0;
      elem_last_d  = elem_cnt - CNT_ONE;
      frame_last_d = frame_cnt - CNT_ONE;
    end else if (adv) begin
      if (xfer_end) begin
        elem_idx_d  = '0;
        frame_idx_d = '0;
      end else if (elem_end) begin
        elem_idx_d  = '0;
        frame_idx_d = frame_idx_q + CNT_ONE;
      end else begin
        elem_idx_d  = elem_idx_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_idx_q   <= '0;
      frame_idx_q  <= '0;
      elem_last_q  <= '0;
      frame_last_q <= '0;
    end else if (upd_en) begin
      elem_idx_q   <= elem_idx_d;
      frame_idx_q  <= frame_idx_d;
      elem_last_q  <= elem_last_d;
      frame_last_q <= frame_last_d;
    end
  end

  // R10: position never runs past the captured element limit
  a_r10_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    elem_idx_q <= elem_last_q);

  // R6: frame position never runs past the captured frame limit
  a_r6_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx_q <= frame_last_q);

endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              frame_wrap,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] esize,
  input  logic [IDX_W-1:0]  estride,
  input  logic [IDX_W-1:0]  fgap,
  output logic [ADDR_W-1:0] addr
);

  logic [SIZE_W-1:0] esize_q;
  logic [IDX_W-1:0]  estride_q;
  logic [IDX_W-1:0]  fgap_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] elem_step, frame_step;
  logic              addr_en;

  assign elem_step  = (estride_q == '0) ? ADDR_W'(esize_q) : ADDR_W'(estride_q);
  assign frame_step = ADDR_W'(esize_q) + ADDR_W'(fgap_q);
  assign addr_en    = load | adv;

  always_comb begin
    if (load)            addr_d = base;
    else if (frame_wrap) addr_d = addr_q + frame_step;
    else                 addr_d = addr_q + elem_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esize_q   <= '0;
      estride_q <= '0;
      fgap_q    <= '0;
    end else if (load) begin
      esize_q   <= esize;
      estride_q <= estride;
      fgap_q    <= fgap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
  import dma2d_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_ext_size,
  input  logic              cfg_two_d,
  input  logic [SIZE_W-1:0] cfg_elem_size,
  input  logic [CNT_W-1:0]  cfg_elem_cnt,
  input  logic [CNT_W-1:0]  cfg_frame_cnt,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [IDX_W-1:0]  cfg_src_elem_idx,
  input  logic [IDX_W-1:0]  cfg_dst_elem_idx,
  input  logic [IDX_W-1:0]  cfg_src_frame_gap,
  input  logic [IDX_W-1:0]  cfg_dst_frame_gap,
  output logic              busy,
  output logic              err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_src_addr,
  output logic [ADDR_W-1:0] out_dst_addr,
  output logic [SIZE_W-1:0] out_size,
  output logic              done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_e        state_q, state_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [SIZE_W-1:0] size_q;
  logic              legal, idle, accept, load, fire;
  logic              elem_end, xfer_end;
  logic [CNT_W-1:0]  frame_cnt_eff;

  logic [ADDR_W-1:0] side_base   [NUM_SIDES];
  logic [IDX_W-1:0]  side_stride [NUM_SIDES];
  logic [IDX_W-1:0]  side_gap    [NUM_SIDES];
  logic [ADDR_W-1:0] side_addr   [NUM_SIDES];

  // ---------------- parameter check and control ----------------
  assign legal = size_legal(cfg_ext_size, 32'(cfg_elem_size))
              && (cfg_elem_cnt != '0)
              && (!cfg_two_d || (cfg_frame_cnt != '0));

  assign idle          = (state_q == SEQ_IDLE);
  assign accept        = start && idle;
  assign load          = accept && legal;
  assign fire          = out_valid && out_ready;
  assign frame_cnt_eff = cfg_two_d ? cfg_frame_cnt : CNT_ONE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (load)             state_d = SEQ_RUN;
      SEQ_RUN:  if (fire && xfer_end) state_d = SEQ_IDLE;
      default:                        state_d = SEQ_IDLE;
    endcase
    done_d = (state_q == SEQ_RUN) && fire && xfer_end;
    err_d  = accept && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    size_q <= '0;
    else if (load) size_q <= cfg_elem_size;
  end

  // ---------------- element / frame position ----------------
  dma2d_pos_ctr #(.CNT_W(CNT_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .adv       (fire),
    .elem_cnt  (cfg_elem_cnt),
    .frame_cnt (frame_cnt_eff),
    .elem_end  (elem_end),
    .xfer_end  (xfer_end)
  );

  // ---------------- per-side address steppers ----------------
  assign side_base[SIDE_SRC]   = cfg_src_base;
  assign side_base[SIDE_DST]   = cfg_dst_base;
  assign side_stride[SIDE_SRC] = cfg_src_elem_idx;
  assign side_stride[SIDE_DST] = cfg_dst_elem_idx;
  assign side_gap[SIDE_SRC]    = cfg_src_frame_gap;
  assign side_gap[SIDE_DST]    = cfg_dst_frame_gap;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dma2d_addr_step #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .IDX_W  (IDX_W)
    ) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .adv        (fire),
      .frame_wrap (elem_end),
      .base       (side_base[s]),
      .esize      (cfg_elem_size),
      .estride    (side_stride[s]),
      .fgap       (side_gap[s]),
      .addr       (side_addr[s])
    );
  end

  assign busy         = (state_q == SEQ_RUN);
  assign out_valid    = busy;
  assign out_src_addr = side_addr[SIDE_SRC];
  assign out_dst_addr = side_addr[SIDE_DST];
  assign out_size     = size_q;
  assign done         = done_q;
  assign err          = err_q;

  // ---------------- assertions ----------------
  // R9: offered pair held under back-pressure
  a_r9_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src_addr)
                                && $stable(out_dst_addr) && $stable(out_size));

  // R2: a start while idle either begins a transfer or is rejected
  a_r2_start_acts: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy || err);

  // R7: a rejected start leaves the block idle
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !out_valid && !done);

  // R8: a start while busy never ends the transfer early
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !out_ready |=> busy && $stable(out_src_addr));

  // R10: done is a single-cycle pulse and the block is idle with it
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);

endmodule

// File: tb/dma2d_addr_seq_tb.sv
`timescale 1ns/1ps
module dma2d_addr_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        cfg_ext_size;
  logic        cfg_two_d;
  logic [15:0] cfg_elem_size;
  logic [15:0] cfg_elem_cnt;
  logic [15:0] cfg_frame_cnt;
  logic [31:0] cfg_src_base;
  logic [31:0] cfg_dst_base;
  logic [15:0] cfg_src_elem_idx;
  logic [15:0] cfg_dst_elem_idx;
  logic [15:0] cfg_src_frame_gap;
  logic [15:0] cfg_dst_frame_gap;
  logic        busy, err, out_valid, out_ready, done;
  logic [31:0] out_src_addr, out_dst_addr;
  logic [15:0] out_size;

  int n_chk;
  int n_fail;

  dma2d_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_ext_size(cfg_ext_size), .cfg_two_d(cfg_two_d),
    .cfg_elem_size(cfg_elem_size), .cfg_elem_cnt(cfg_elem_cnt),
    .cfg_frame_cnt(cfg_frame_cnt),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_elem_idx(cfg_src_elem_idx), .cfg_dst_elem_idx(cfg_dst_elem_idx),
    .cfg_src_frame_gap(cfg_src_frame_gap), .cfg_dst_frame_gap(cfg_dst_frame_gap),
    .busy(busy), .err(err), .out_valid(out_valid), .out_ready(out_ready),
    .out_src_addr(out_src_addr), .out_dst_addr(out_dst_addr),
    .out_size(out_size), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Model of the next address of one side after an element is accepted
  function automatic logic [31:0] next_addr(input logic [31:0] cur, input bit frame_end,
                                            input logic [15:0] sz, input logic [15:0] stride,
                                            input logic [15:0] gap);
    if (frame_end)         return cur + 32'(sz) + 32'(gap);
    if (stride == 16'd0)   return cur + 32'(sz);
    return cur + 32'(stride);
  endfunction

  function automatic string step_tag(input bit frame_end, input logic [15:0] sst, input logic [15:0] dst);
    if (frame_end) return "R5";
    if (sst == 16'd0 || dst == 16'd0) return "R4";
    return "R3";
  endfunction

  task automatic set_cfg(input bit ext, input bit twod, input logic [15:0] sz,
                         input logic [15:0] ec, input logic [15:0] fc,
                         input logic [31:0] sb, input logic [31:0] db,
                         input logic [15:0] sst, input logic [15:0] dst,
                         input logic [15:0] sg, input logic [15:0] dg);
    cfg_ext_size = ext; cfg_two_d = twod; cfg_elem_size = sz;
    cfg_elem_cnt = ec; cfg_frame_cnt = fc; cfg_src_base = sb; cfg_dst_base = db;
    cfg_src_elem_idx = sst; cfg_dst_elem_idx = dst;
    cfg_src_frame_gap = sg; cfg_dst_frame_gap = dg;
  endtask

  // Runs one legal transfer, entered and left at a falling edge
  task automatic run_xfer(input bit ext, input bit twod, input logic [15:0] sz,
                          input logic [15:0] ec, input logic [15:0] fc,
                          input logic [31:0] sb, input logic [31:0] db,
                          input logic [15:0] sst, input logic [15:0] dst,
                          input logic [15:0] sg, input logic [15:0] dg,
                          input bit inject, input string tag_ovr);
    int total, cnt, e, guard;
    logic [31:0] es, ed, ps, pd;
    bit stall_prev, injected, fe;
    string tg;
    total = int'(ec) * (twod ? int'(fc) : 1);
    set_cfg(ext, twod, sz, ec, fc, sb, db, sst, dst, sg, dg);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && out_valid, "R2 busy/valid after start", {62'd0, busy, out_valid}, 64'd3);
    chk(out_size == sz, "R2 out_size", 64'(out_size), 64'(sz));
    es = sb; ed = db; e = 0; cnt = 0; guard = 0;
    tg = "R2"; stall_prev = 1'b0; injected = 1'b0; ps = '0; pd = '0;
    while (cnt < total && guard < 5000) begin
      guard++;
      if (inject && cnt == 1 && !injected) begin
        injected = 1'b1;
        start = 1'b1;
        set_cfg(~ext, ~twod, 16'd3, 16'd9, 16'd9, ~sb, ~db, 16'd5, 16'd6, 16'd7, 16'd8);
      end else begin
        start = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      if (stall_prev)
        chk(out_valid && out_src_addr == ps && out_dst_addr == pd, "R9 hold under stall",
            {out_src_addr, out_dst_addr}, {ps, pd});
      if (out_ready) begin
        chk(out_valid && out_src_addr == es && out_dst_addr == ed,
            (tag_ovr != "") ? tag_ovr : tg, {out_src_addr, out_dst_addr}, {es, ed});
        fe = (e == int'(ec) - 1);
        tg = step_tag(fe, sst, dst);
        es = next_addr(es, fe, sz, sst, sg);
        ed = next_addr(ed, fe, sz, dst, dg);
        e  = fe ? 0 : e + 1;
        cnt++;
      end
      stall_prev = !out_ready;
      ps = out_src_addr; pd = out_dst_addr;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(guard < 5000, "R10 transfer completes", 64'(cnt), 64'(total));
    chk(done && !busy && !out_valid, twod ? "R10 done after last" : "R6 done after one frame",
        {61'd0, done, busy, out_valid}, 64'd4);
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic try_bad(input bit ext, input bit twod, input logic [15:0] sz,
                         input logic [15:0] ec, input logic [15:0] fc, input string tag);
    set_cfg(ext, twod, sz, ec, fc, 32'h100, 32'h200, 16'd0, 16'd0, 16'd0, 16'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !out_valid, tag, {61'd0, err, busy, out_valid}, 64'd4);
    @(negedge clk);
    chk(!err && !busy, {tag, " err one cycle"}, {62'd0, err, busy}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    set_cfg(1'b0, 1'b0, 16'd1, 16'd1, 16'd1, '0, '0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done && !err, "R1 reset state",
        {60'd0, busy, out_valid, done, err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done && !err, "R1 idle after reset",
        {60'd0, busy, out_valid, done, err}, 64'd0);

    // Directed: 2-D with distinct per-side strides and gaps
    run_xfer(1'b0, 1'b1, 16'd4, 16'd3, 16'd3, 32'h1000, 32'h8000,
             16'd12, 16'd0, 16'd16, 16'd4, 1'b0, "");
    // Directed: 1-D, frame count ignored (nonzero and zero)
    run_xfer(1'b0, 1'b0, 16'd2, 16'd4, 16'd5, 32'h40, 32'h80,
             16'd2, 16'd6, 16'd100, 16'd100, 1'b0, "");
    run_xfer(1'b1, 1'b0, 16'd7, 16'd3, 16'd0, 32'h0, 32'h10,
             16'd0, 16'd9, 16'd0, 16'd0, 1'b0, "R6 zero frame count in 1-D");
    // Directed: single element
    run_xfer(1'b0, 1'b1, 16'd1, 16'd1, 16'd1, 32'hABCD, 32'h1234,
             16'd0, 16'd0, 16'd0, 16'd0, 1'b0, "");
    // Directed: wrap of both sides
    run_xfer(1'b0, 1'b1, 16'd4, 16'd3, 16'd2, 32'hFFFF_FFF8, 32'hFFFF_FFFC,
             16'd8, 16'd0, 16'd4, 16'd0, 1'b0, "R11 wrap");
    // Directed: extended-mode odd size
    run_xfer(1'b1, 1'b1, 16'd3, 16'd2, 16'd2, 32'h200, 32'h300,
             16'd0, 16'd5, 16'd1, 16'd2, 1'b0, "R7 extended size legal");
    // Directed: start while busy
    run_xfer(1'b0, 1'b1, 16'd2, 16'd4, 16'd2, 32'h500, 32'h900,
             16'd4, 16'd2, 16'd8, 16'd0, 1'b1, "R8 start while busy");

    // Rejected parameter sets
    try_bad(1'b0, 1'b1, 16'd3, 16'd2, 16'd2, "R7 basic size 3");
    try_bad(1'b0, 1'b1, 16'd8, 16'd2, 16'd2, "R7 basic size 8");
    try_bad(1'b1, 1'b1, 16'd0, 16'd2, 16'd2, "R7 size 0");
    try_bad(1'b0, 1'b1, 16'd4, 16'd0, 16'd2, "R7 zero elements");
    try_bad(1'b0, 1'b1, 16'd4, 16'd2, 16'd0, "R7 zero frames 2-D");

    // Random transfers
    for (int i = 0; i < 30; i++) begin
      bit ext, twod;
      logic [15:0] sz, ec, fc, sst, dst, sg, dg;
      logic [31:0] sb, db;
      ext  = $urandom % 2;
      twod = $urandom % 2;
      if (ext) sz = 16'(1 + $urandom % 300);
      else     sz = 16'(1 << ($urandom % 3));
      ec  = 16'(1 + $urandom % 6);
      fc  = 16'(1 + $urandom % 4);
      sst = (($urandom % 3) == 0) ? 16'd0 : 16'($urandom % 64);
      dst = (($urandom % 3) == 0) ? 16'd0 : 16'($urandom % 64);
      sg  = 16'($urandom % 64);
      dg  = 16'($urandom % 64);
      sb  = $urandom;
      db  = $urandom;
      run_xfer(ext, twod, sz, ec, fc, sb, db, sst, dst, sg, dg, (i % 5) == 0, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule